// File: doc/BRIEF.md
# Radian-Wrapped Phase Accumulator

This block produces the phase ramp that drives a numerically controlled oscillator. On every enabled clock cycle it adds an unsigned frequency control word to a signed phase register. The phase is held in radians as 16-bit two's-complement fixed point, with 3 integer bits and 13 fraction bits. Whenever a sum climbs above the code for plus pi (0x6488), the block subtracts the code for two pi (51472) from it. The ramp therefore stays inside minus pi to plus pi, and the fraction left over after a wrap is kept.

A downstream sine/cosine stage takes `phase` directly. `phase_vld` marks the cycles in which the phase has just advanced. A larger control word gives larger steps and more frequent wraps, and so a higher output frequency. The reset input is asynchronous and active-low. Inside the block its release is synchronised, so the accumulator starts stepping on the third rising edge after `rst_n` rises.

Top module: `rad_phase_acc`

## Requirements
- R1: While `rst_n` is low, and through the first two rising edges after it goes high, `phase` reads 0x0000 and `phase_vld` reads 0, whatever `en` is.
- R2: On a rising edge with `en` high and with the signed sum of the old phase and `fcw` at or below 25736 (0x6488), the new phase is exactly that sum. `fcw` is sampled on that same edge, so a changed word applies from the next enabled step.
- R3: On a rising edge with `en` high and with that sum above 25736, the new phase is the sum minus 51472. A sum equal to 25736 is kept and not wrapped.
- R4: For any `fcw` in 1..51471, `phase` read as a signed value always lies in -25736..25736.
- R5: A rising edge with `en` low leaves `phase` unchanged and drives `phase_vld` to 0.
- R6: After every rising edge with `en` high, past the reset window, `phase_vld` is 1.
- R7: After K enabled steps from zero with a constant word F, the number of wraps is floor((K*F + 25735) / 51472) and the phase equals K*F minus 51472 times that count. No error builds up, and a larger F yields more wraps over the same K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| en | input | 1 | Step enable; phase advances on edges where this is high |
| fcw | input | 16 | Unsigned frequency control word, legal range 1..51471 |
| phase | output | 16 | Signed Q3.13 phase in radians |
| phase_vld | output | 1 | High in the cycle after an enabled step |

## Verification
The bound checker checks on every cycle that the phase stays in range and that it is zero during reset. It also checks that each enabled step either adds the word or adds it and removes two pi, depending on the plus-pi threshold. Finally it checks that a disabled edge freezes the phase and that the valid flag follows the enable. Only the bench's scenarios can show that the phase tracks the closed-form model over long runs without drift, that the wrap count matches the word across several words, and that reset release lands on the expected edge. The same holds for the exact-pi boundary and for a word changed mid-run.

// File: rtl/rad_phase_pkg.sv
`timescale 1ns/1ps
package rad_phase_pkg;
  // Q3.13 radians: 3 integer bits (sign included), 13 fraction bits
  localparam int PHASE_W_DEF     = 16;
  localparam int PI_CODE_DEF     = 25736;  // 0x6488
  localparam int SYNC_STAGES_DEF = 2;

  // headroom for old phase (up to +pi) plus an unsigned word (< 2*pi)
  function automatic int sum_width(input int phase_w);
    return phase_w + 2;
  endfunction

  function automatic int two_pi_code(input int pi_code);
    return 2 * pi_code;
  endfunction
endpackage

// File: rtl/rad_rst_sync.sv
`timescale 1ns/1ps
module rad_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/rad_phase_next.sv
`timescale 1ns/1ps
module rad_phase_next
  import rad_phase_pkg::*;
#(
  parameter int PHASE_W = PHASE_W_DEF,
  parameter int PI_CODE = PI_CODE_DEF
) (
  input  logic [PHASE_W-1:0] phase_cur,
  input  logic [PHASE_W-1:0] step_word,
  output logic [PHASE_W-1:0] phase_nxt
);
  localparam int SUM_W = sum_width(PHASE_W);
  localparam logic signed [SUM_W-1:0] PI_S     = SUM_W'(PI_CODE);
  localparam logic signed [SUM_W-1:0] TWO_PI_S = SUM_W'(two_pi_code(PI_CODE));

  logic signed [SUM_W-1:0] raw_sum;
  logic                    over_pi;

  always_comb begin
    raw_sum   = $signed({{(SUM_W-PHASE_W){phase_cur[PHASE_W-1]}}, phase_cur})
              + $signed({{(SUM_W-PHASE_W){1'b0}}, step_word});
    over_pi   = (raw_sum > PI_S);
    // remove one full turn; the residual fraction is preserved
    phase_nxt = PHASE_W'(over_pi ? (raw_sum - TWO_PI_S) : raw_sum);
  end
endmodule

// File: rtl/rad_phase_reg.sv
`timescale 1ns/1ps
module rad_phase_reg #(
  parameter int PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_en,
  input  logic [PHASE_W-1:0] phase_nxt,
  output logic [PHASE_W-1:0] phase_q,
  output logic               vld_q
);
  logic [PHASE_W-1:0] phase_d;
  logic               vld_d;

  always_comb begin
    phase_d = step_en ? phase_nxt : phase_q;
    vld_d   = step_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      vld_q   <= vld_d;
    end
  end
endmodule

// File: rtl/rad_phase_acc.sv
`timescale 1ns/1ps
module rad_phase_acc
  import rad_phase_pkg::*;
#(
  parameter int PHASE_W     = PHASE_W_DEF,
  parameter int PI_CODE     = PI_CODE_DEF,
  parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [PHASE_W-1:0] fcw,
  output logic [PHASE_W-1:0] phase,
  output logic               phase_vld
);
  logic               core_rst_n;
  logic [PHASE_W-1:0] phase_nxt;

  rad_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  rad_phase_next #(.PHASE_W(PHASE_W), .PI_CODE(PI_CODE)) next_i (
    .phase_cur (phase),
    .step_word (fcw),
    .phase_nxt (phase_nxt)
  );

  rad_phase_reg #(.PHASE_W(PHASE_W)) reg_i (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .step_en   (en),
    .phase_nxt (phase_nxt),
    .phase_q   (phase),
    .vld_q     (phase_vld)
  );
endmodule

// File: rtl/rad_phase_acc_chk.sv
`timescale 1ns/1ps
module rad_phase_acc_chk #(
  parameter int PHASE_W = 16,
  parameter int PI_CODE = 25736
) (
  input logic               clk,
  input logic               rst_n,
  input logic               core_rst_n,
  input logic               en,
  input logic [PHASE_W-1:0] fcw,
  input logic [PHASE_W-1:0] phase,
  input logic               phase_vld
);
  localparam int PI_I     = PI_CODE;
  localparam int TWO_PI_I = 2 * PI_CODE;

  int ph_i;
  int cand;
  always_comb begin
    ph_i = int'($signed(phase));
    cand = ph_i + int'(fcw);
  end

  assert_reset_R1: assert property (@(posedge clk)
    !core_rst_n |-> (phase == '0) && !phase_vld);

  assert_step_R2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (en && cand <= PI_I) |=> ph_i == $past(cand));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
    (en && cand > PI_I) |=> ph_i == $past(cand) - TWO_PI_I);

  assert_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_i >= -PI_I) && (ph_i <= PI_I));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
    !en |=> $stable(phase) && !phase_vld);

  assert_vld_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
    en |=> phase_vld);
endmodule

bind rad_phase_acc rad_phase_acc_chk #(.PHASE_W(PHASE_W), .PI_CODE(PI_CODE)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_rst_n (core_rst_n),
  .en         (en),
  .fcw        (fcw),
  .phase      (phase),
  .phase_vld  (phase_vld)
);

// File: tb/rad_phase_acc_tb_top.sv
`timescale 1ns/1ps
module rad_phase_acc_tb_top;
  localparam longint PI_L  = 25736;
  localparam longint TPI_L = 51472;

  logic        clk;
  logic        rst_n;
  logic        en;
  logic [15:0] fcw;
  logic [15:0] phase;
  logic        phase_vld;

  int     total;
  int     bad;
  bit     done;
  longint ref_u;

  rad_phase_acc dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .fcw       (fcw),
    .phase     (phase),
    .phase_vld (phase_vld)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint ph_now();
    return longint'($signed(phase));
  endfunction

  function automatic longint wraps_of(input longint u);
    return (u + PI_L - 1) / TPI_L;
  endfunction

  function automatic longint model_phase(input longint u);
    return u - TPI_L * wraps_of(u);
  endfunction

  // one enabled step with word w, checked against the closed-form model
  task automatic step(input int w);
    en  = 1'b1;
    fcw = 16'(w);
    @(posedge clk);
    @(negedge clk);
    ref_u += w;
    chk("R2/R3 phase", ph_now(), model_phase(ref_u));
    chk("R6 vld", longint'(phase_vld), 1);
    total++;
    if (ph_now() < -PI_L || ph_now() > PI_L) begin
      bad++;
      $display("FAIL R4: actual=%0d expected within +-%0d", ph_now(), PI_L);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0; fcw = 16'd100;
    #1;
    chk("R1 phase in reset", ph_now(), 0);
    chk("R1 vld in reset", longint'(phase_vld), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1; en = 1'b1;   // enable during release window
    repeat (2) @(negedge clk);
    chk("R1 phase in release window", ph_now(), 0);
    chk("R1 vld in release window", longint'(phase_vld), 0);
    en = 1'b0;
    @(negedge clk);
    ref_u = 0;
  endtask

  task automatic t_exact_pi();
    t_reset();
    step(25736);
    chk("R3 exact pi kept", ph_now(), 25736);
    step(25736);
    chk("R3 wrap to zero", ph_now(), 0);
  endtask

  task automatic t_max_word();
    t_reset();
    step(51471);
    chk("R3 max word", ph_now(), -1);
    for (int k = 0; k < 20; k++) step(51471);
  endtask

  task automatic t_hold();
    t_reset();
    for (int k = 0; k < 7; k++) step(3000);
    begin
      longint held = ph_now();
      en = 1'b0; fcw = 16'd9999;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        chk("R5 phase held", ph_now(), held);
        chk("R5 vld low", longint'(phase_vld), 0);
      end
    end
    for (int k = 0; k < 5; k++) step(3000);
  endtask

  task automatic t_word_change();
    t_reset();
    for (int k = 0; k < 10; k++) step(4000);
    for (int k = 0; k < 10; k++) step(17);
    for (int k = 0; k < 10; k++) step(30001);
  endtask

  task automatic t_period(input int w, input int k_steps, output longint wraps);
    longint prev;
    t_reset();
    wraps = 0;
    prev  = ph_now();
    for (int k = 0; k < k_steps; k++) begin
      step(w);
      if (ph_now() < prev) wraps++;
      prev = ph_now();
    end
    chk("R7 wrap count", wraps, wraps_of(longint'(w) * k_steps));
    chk("R7 final phase", ph_now(), longint'(w) * k_steps - TPI_L * wraps);
  endtask

  task automatic t_freq_order();
    longint w_lo, w_hi, w_tiny;
    t_period(1000, 2000, w_lo);
    t_period(2600, 2000, w_hi);
    t_period(1, 300, w_tiny);
    chk("R7 larger word more wraps", longint'(w_hi > w_lo), 1);
    chk("R7 tiny word no wrap", w_tiny, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    total = 0; bad = 0; done = 1'b0; ref_u = 0;
    rst_n = 1'b0; en = 1'b0; fcw = '0;
    t_reset();
    t_exact_pi();
    t_max_word();
    t_hold();
    t_word_change();
    t_freq_order();
    finish_run();
  end
endmodule